// File: doc/BRIEF.md
# Receive Character Buffer with Idle Timeout

This block is the receive-side store of an asynchronous serial port. It sits between the receiver's shift register and a byte-wide CPU read port. Each completed character arrives on a one-cycle strobe together with its parity, framing and break flags. Character and flags are kept as one entry in a 16-deep first-in first-out buffer, and the CPU sees the oldest entry at the head. The block raises a fill-level request at a programmable threshold. It also raises a character-timeout request when stored data has sat untouched for four character times. It keeps an overrun flag and an error summary for the line status path.

The idle timer is a three-state machine. TM_EMPTY means no data is stored. TM_WAIT means data is stored and character-time ticks are being counted. TM_FIRED means the timeout request is raised. The transitions are:
- "first store": TM_EMPTY to TM_WAIT.
- "restart": TM_WAIT to TM_WAIT, on a store or a read.
- "expire": TM_WAIT to TM_FIRED, on the fourth idle tick.
- "read clear": TM_FIRED to TM_WAIT, or to TM_EMPTY when the read drains the buffer. TM_WAIT also goes to TM_EMPTY on such a read.
- "flush": any state to TM_EMPTY.

Top module: `rx_char_fifo`

## Requirements
- R1: Stored characters come out in arrival order. `head_data` and the head flags show the oldest entry, and all read 0 when the buffer is empty. `data_ready` is 1 exactly when at least one entry is stored. Up to 16 entries are held.
- R2: `lvl_sel` picks the fill threshold: 0 gives 1 entry, 1 gives 4, 2 gives 8 and 3 gives 14. `lvl_req` is 1 while the occupancy is at or above that threshold, and 0 once the occupancy falls below it.
- R3: A character that completes while 16 entries are stored is dropped and not written. This holds even if a read happens in the same cycle. The drop sets `overrun`, which stays 1 until a `stat_rd` pulse clears it. A new drop in the same cycle as `stat_rd` wins.
- R4: `head_perr`, `head_ferr` and `head_brk` are the flags stored with the head character only. Flags of entries behind the head are not visible.
- R5: `err_any` becomes 1 when a character with any flag set is stored. A `stat_rd` pulse clears it only if no stored entry carries a flag at that cycle; otherwise it stays 1.
- R6: `timeout_req` becomes 1 after four `char_tick` pulses with at least one entry stored and no store and no read since the last restart. Ticks while the buffer is empty have no effect.
- R7: A stored character or a read restarts the tick count. A read also clears `timeout_req`. A character stored while `timeout_req` is 1 does not clear it.
- R8: `flush` empties the buffer and clears `timeout_req`, and a character arriving in the same cycle is not stored. `overrun` is unchanged by it.
- R9: A `pop` pulse while the buffer is empty has no effect on any output.
- R10: After reset the buffer is empty, and `overrun`, `err_any`, `lvl_req` and `timeout_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_valid | input | 1 | One-cycle strobe: a character has completed |
| char_data | input | 8 | Received character |
| char_perr | input | 1 | Parity error of the character |
| char_ferr | input | 1 | Framing error of the character |
| char_brk | input | 1 | Break detected for the character |
| pop | input | 1 | CPU read of the head entry |
| stat_rd | input | 1 | CPU read of the line status |
| flush | input | 1 | Empty the buffer |
| lvl_sel | input | 2 | Threshold select |
| char_tick | input | 1 | One pulse per character time |
| head_data | output | 8 | Head character |
| head_perr | output | 1 | Parity flag of the head |
| head_ferr | output | 1 | Framing flag of the head |
| head_brk | output | 1 | Break flag of the head |
| data_ready | output | 1 | Buffer not empty |
| overrun | output | 1 | Sticky drop flag |
| err_any | output | 1 | Error summary |
| lvl_req | output | 1 | Threshold reached |
| timeout_req | output | 1 | Idle timeout pending |

## Verification
Every strobe takes effect at the next rising edge. The head, `data_ready`, `lvl_req`, `overrun`, `err_any` and `timeout_req` therefore all show the result one clock after the strobe is sampled. The threshold request is decoded without a register from the stored count, so it moves in the same cycle as `data_ready`. The bench drives each strobe for one clock starting at a falling edge and samples at the next falling edge. This puts every check half a cycle after the edge that produced the result. The timeout is due in the cycle after the fourth qualifying tick, so the bench checks the value after the third tick and again after the fourth.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef struct packed {
        logic       perr;
        logic       ferr;
        logic       brk;
        logic [7:0] data;
    } rxf_entry_t;

    typedef enum logic [1:0] {
        TM_EMPTY = 2'd0,
        TM_WAIT  = 2'd1,
        TM_FIRED = 2'd2
    } tmr_state_e;

    function automatic int unsigned lvl_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  rxf_entry_t      wr_entry,
    input  logic            rd_req,
    input  logic            clr,
    output rxf_entry_t      head,
    output logic [CW-1:0]   count,
    output logic [CW-1:0]   count_after,
    output logic            pushed,
    output logic            popped,
    output logic            dropped
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    rxf_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, empty;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign pushed  = wr_req && !full && !clr;
    assign popped  = rd_req && !empty && !clr;
    assign dropped = wr_req && full && !clr;

    always_comb begin
        count_after = count;
        if (clr)
            count_after = '0;
        else if (pushed && !popped)
            count_after = count + 1'b1;
        else if (popped && !pushed)
            count_after = count - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_after;
            if (clr) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (pushed)
                    wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
                if (popped)
                    rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (pushed)
            mem[wr_ptr] <= wr_entry;
    end

    assign head = empty ? '0 : mem[rd_ptr];

endmodule

// File: rtl/rxf_timer.sv
module rxf_timer
    import rxf_pkg::*;
#(
    parameter int IDLE_CHARS = 4,
    parameter int CW = 5,
    localparam int TW = $clog2(IDLE_CHARS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          pushed,
    input  logic          popped,
    input  logic          tick,
    input  logic [CW-1:0] count_after,
    output logic          timeout_req
);
    localparam logic [TW-1:0] LIMIT = TW'(IDLE_CHARS);
    localparam logic [TW-1:0] LAST  = TW'(IDLE_CHARS - 1);

    tmr_state_e    state, state_nxt;
    logic [TW-1:0] ticks;

    always_comb begin
        state_nxt = state;
        unique case (state)
            TM_EMPTY: if (pushed) state_nxt = TM_WAIT;
            TM_WAIT: begin
                if (popped)
                    state_nxt = (count_after == '0) ? TM_EMPTY : TM_WAIT;
                else if (!pushed && tick && ticks == LAST)
                    state_nxt = TM_FIRED;
            end
            TM_FIRED: begin
                if (popped)
                    state_nxt = (count_after == '0) ? TM_EMPTY : TM_WAIT;
            end
            default: state_nxt = TM_EMPTY;
        endcase
        if (clr)
            state_nxt = TM_EMPTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TM_EMPTY;
            ticks <= '0;
        end else begin
            state <= state_nxt;
            if (clr || pushed || popped)
                ticks <= '0;
            else if (tick && state == TM_WAIT && ticks != LIMIT)
                ticks <= ticks + 1'b1;
        end
    end

    always_comb begin
        timeout_req = (state == TM_FIRED);
    end

endmodule

// File: rtl/rxf_status.sv
module rxf_status
    import rxf_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          pushed,
    input  logic          popped,
    input  logic          dropped,
    input  logic          stat_rd,
    input  logic          in_err,
    input  logic          head_err,
    input  logic [CW-1:0] count,
    input  logic [1:0]    lvl_sel,
    output logic          overrun,
    output logic          err_any,
    output logic          lvl_req
);
    logic [CW-1:0] err_cnt;
    logic          put_err, take_err;

    assign put_err  = pushed && in_err;
    assign take_err = popped && head_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_cnt <= '0;
            err_any <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (clr)
                err_cnt <= '0;
            else if (put_err && !take_err)
                err_cnt <= err_cnt + 1'b1;
            else if (take_err && !put_err)
                err_cnt <= err_cnt - 1'b1;

            if (put_err)
                err_any <= 1'b1;
            else if (stat_rd && err_cnt == '0)
                err_any <= 1'b0;

            if (dropped)
                overrun <= 1'b1;
            else if (stat_rd)
                overrun <= 1'b0;
        end
    end

    assign lvl_req = (32'(count) >= lvl_of(lvl_sel));

endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int IDLE_CHARS = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       char_valid,
    input  logic [7:0] char_data,
    input  logic       char_perr,
    input  logic       char_ferr,
    input  logic       char_brk,
    input  logic       pop,
    input  logic       stat_rd,
    input  logic       flush,
    input  logic [1:0] lvl_sel,
    input  logic       char_tick,
    output logic [7:0] head_data,
    output logic       head_perr,
    output logic       head_ferr,
    output logic       head_brk,
    output logic       data_ready,
    output logic       overrun,
    output logic       err_any,
    output logic       lvl_req,
    output logic       timeout_req
);
    rxf_entry_t    in_entry, head;
    logic [CW-1:0] count, count_after;
    logic          pushed, popped, dropped;

    assign in_entry = '{perr: char_perr, ferr: char_ferr, brk: char_brk, data: char_data};

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_req(char_valid), .wr_entry(in_entry),
        .rd_req(pop), .clr(flush),
        .head(head), .count(count), .count_after(count_after),
        .pushed(pushed), .popped(popped), .dropped(dropped)
    );

    rxf_timer #(.IDLE_CHARS(IDLE_CHARS), .CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .pushed(pushed), .popped(popped), .tick(char_tick),
        .count_after(count_after), .timeout_req(timeout_req)
    );

    rxf_status #(.CW(CW)) u_status (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .pushed(pushed), .popped(popped), .dropped(dropped),
        .stat_rd(stat_rd),
        .in_err(char_perr | char_ferr | char_brk),
        .head_err(head.perr | head.ferr | head.brk),
        .count(count), .lvl_sel(lvl_sel),
        .overrun(overrun), .err_any(err_any), .lvl_req(lvl_req)
    );

    assign head_data  = head.data;
    assign head_perr  = head.perr;
    assign head_ferr  = head.ferr;
    assign head_brk   = head.brk;
    assign data_ready = (count != '0);

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int CW = 5,
    parameter int DEPTH = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          char_valid,
    input logic          pop,
    input logic          stat_rd,
    input logic          flush,
    input logic [1:0]    lvl_sel,
    input logic          data_ready,
    input logic          overrun,
    input logic          lvl_req,
    input logic          timeout_req,
    input logic [CW-1:0] count
);
    p_depth_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) <= DEPTH);

    p_lvl_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_sel == 2'd0) |-> (lvl_req == data_ready));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && !flush && 32'(count) == DEPTH) |=> overrun);

    p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !stat_rd) |=> overrun);

    p_tmo_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_req |-> data_ready);

    p_read_clears_tmo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && data_ready) |=> !timeout_req);

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!data_ready && !timeout_req));

    p_flush_keeps_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !stat_rd && !char_valid) |=> (overrun == $past(overrun)));
endmodule

bind rx_char_fifo rxf_checker #(.CW(CW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .pop(pop),
    .stat_rd(stat_rd), .flush(flush), .lvl_sel(lvl_sel),
    .data_ready(data_ready), .overrun(overrun), .lvl_req(lvl_req),
    .timeout_req(timeout_req), .count(count)
);

// File: tb/tb_rx_char_fifo.sv
module tb_rx_char_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_valid = 1'b0, char_perr = 1'b0, char_ferr = 1'b0, char_brk = 1'b0;
    logic [7:0] char_data = '0;
    logic       pop = 1'b0, stat_rd = 1'b0, flush = 1'b0, char_tick = 1'b0;
    logic [1:0] lvl_sel = 2'd0;
    logic [7:0] head_data;
    logic       head_perr, head_ferr, head_brk;
    logic       data_ready, overrun, err_any, lvl_req, timeout_req;

    int checks = 0;
    int failures = 0;

    always #2ns clk = ~clk;

    rx_char_fifo dut (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
        .pop(pop), .stat_rd(stat_rd), .flush(flush), .lvl_sel(lvl_sel),
        .char_tick(char_tick), .head_data(head_data), .head_perr(head_perr),
        .head_ferr(head_ferr), .head_brk(head_brk), .data_ready(data_ready),
        .overrun(overrun), .err_any(err_any), .lvl_req(lvl_req),
        .timeout_req(timeout_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d, input logic p, input logic f, input logic b);
        char_valid = 1'b1; char_data = d; char_perr = p; char_ferr = f; char_brk = b;
        @(negedge clk);
        char_valid = 1'b0; char_perr = 1'b0; char_ferr = 1'b0; char_brk = 1'b0;
    endtask

    task automatic take();
        pop = 1'b1; @(negedge clk); pop = 1'b0;
    endtask

    task automatic tick();
        char_tick = 1'b1; @(negedge clk); char_tick = 1'b0;
    endtask

    task automatic status_read();
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1; @(negedge clk); flush = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 data_ready", data_ready, 0);
        check("R10 overrun", overrun, 0);
        check("R10 err_any", err_any, 0);
        check("R10 lvl_req", lvl_req, 0);
        check("R10 timeout_req", timeout_req, 0);
        check("R1 empty head", {head_data, head_perr, head_ferr, head_brk}, 0);
    endtask

    task automatic t_fill_overflow();
        do_flush();
        lvl_sel = 2'd3;
        for (int i = 0; i < 16; i++) put(8'h30 + 8'(i), i[0], i[1], i == 5);
        check("R1 full data_ready", data_ready, 1);
        check("R2 level 14 at 16", lvl_req, 1);
        check("R3 no overrun yet", overrun, 0);
        char_valid = 1'b1; char_data = 8'hEE; pop = 1'b1;
        @(negedge clk);
        char_valid = 1'b0; pop = 1'b0;
        check("R3 overrun on full", overrun, 1);
        check("R3 head after pop", head_data, 8'h31);
        for (int i = 1; i < 16; i++) begin
            check("R1 order", head_data, 8'h30 + 8'(i));
            check("R4 head flags", {head_perr, head_ferr, head_brk},
                  {i[0], i[1], (i == 5) ? 1'b1 : 1'b0});
            take();
        end
        check("R3 dropped char absent", data_ready, 0);
        check("R3 overrun sticky", overrun, 1);
        status_read();
        check("R3 overrun cleared", overrun, 0);
    endtask

    task automatic t_levels();
        for (int s = 0; s < 4; s++) begin
            int lv;
            lv = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            do_flush();
            lvl_sel = 2'(s);
            for (int k = 0; k < lv - 1; k++) put(8'(k), 1'b0, 1'b0, 1'b0);
            check("R2 below level", lvl_req, 0);
            put(8'hA5, 1'b0, 1'b0, 1'b0);
            check("R2 at level", lvl_req, 1);
            take();
            check("R2 drop below", lvl_req, 0);
        end
        do_flush();
        lvl_sel = 2'd0;
    endtask

    task automatic t_err_summary();
        status_read();
        check("R5 summary idle", err_any, 0);
        put(8'h01, 1'b0, 1'b0, 1'b0);
        put(8'h02, 1'b1, 1'b0, 1'b0);
        put(8'h03, 1'b0, 1'b0, 1'b0);
        check("R5 set on error entry", err_any, 1);
        check("R4 clean head hides flags", {head_perr, head_ferr, head_brk}, 0);
        take();
        check("R4 error head", head_perr, 1);
        status_read();
        check("R5 held with error stored", err_any, 1);
        take();
        check("R5 sticky after pop", err_any, 1);
        status_read();
        check("R5 cleared when none left", err_any, 0);
        take();
    endtask

    task automatic t_timeout();
        do_flush();
        for (int k = 0; k < 6; k++) tick();
        check("R6 empty ignores ticks", timeout_req, 0);
        put(8'h55, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) tick();
        check("R6 three ticks", timeout_req, 0);
        tick();
        check("R6 fourth tick", timeout_req, 1);
        put(8'h66, 1'b0, 1'b0, 1'b0);
        check("R7 store keeps timeout", timeout_req, 1);
        take();
        check("R7 read clears timeout", timeout_req, 0);
        for (int k = 0; k < 3; k++) tick();
        put(8'h77, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) tick();
        check("R7 store restarts count", timeout_req, 0);
        tick();
        check("R7 expiry after restart", timeout_req, 1);
        do_flush();
        check("R8 flush clears timeout", timeout_req, 0);
        check("R8 flush empties", data_ready, 0);
    endtask

    task automatic t_flush_and_empty();
        put(8'h11, 1'b0, 1'b0, 1'b0);
        char_valid = 1'b1; char_data = 8'h22; flush = 1'b1; pop = 1'b1;
        @(negedge clk);
        char_valid = 1'b0; flush = 1'b0; pop = 1'b0;
        check("R8 flush drops same-cycle char", data_ready, 0);
        for (int i = 0; i < 17; i++) put(8'h40, 1'b0, 1'b0, 1'b0);
        check("R3 overrun before flush", overrun, 1);
        do_flush();
        check("R8 flush keeps overrun", overrun, 1);
        status_read();
        take();
        check("R9 empty read data_ready", data_ready, 0);
        check("R9 empty read overrun", overrun, 0);
        check("R9 empty read head", head_data, 0);
        put(8'h9C, 1'b0, 1'b0, 1'b0);
        check("R9 next char intact", head_data, 8'h9C);
        take();
    endtask

    initial begin
        #800us;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_overflow();
        t_levels();
        t_err_summary();
        t_timeout();
        t_flush_and_empty();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule